// File: doc/BRIEF.md
# PCI I/O Target Controller

This block is the target side of a 32-bit PCI interface for a peripheral whose registers occupy an 8-byte I/O window. It watches the shared address/data and command/byte-enable lines for the start of a transaction. It claims I/O read and I/O write cycles that fall in its window, along with configuration reads and writes selected by the initialization select line. Each completed data phase becomes a single-cycle strobe on a simple internal register bus that carries an address, write data and byte enables, plus a combinational read-data return.

For bursts, the initiator supplies only the first address, and the block produces each following address itself in dword steps. When the next address would leave the window, it signals a disconnect together with the data of the current phase. It drives even parity for the read data it places on the bus. It checks the parity that the initiator supplies for write data and reports a mismatch on the parity-error line.

Each data phase takes one fetch clock followed by a transfer clock. A peripheral that has side effects on read therefore sees exactly one read strobe per completed phase, and sees it before the data is presented.

Top module: `pci_io_target`

## Requirements
- R1: After reset, devsel_n, trdy_n, stop_n and perr_n are high, ad_oe and par_oe are low, and neither reg_rd nor reg_wr is asserted.
- R2: An address phase is the first clock with frame_n low after a clock where both frame_n and irdy_n were high. The block claims the cycle in two cases. The first is command 0010 (I/O read) or 0011 (I/O write) with ad_in[31:3] equal to IO_BASE[31:3]. The second is idsel high with command 1010 (config read) or 1011 (config write) and ad_in[1:0] = 00. All other cycles leave devsel_n and trdy_n high and produce no strobe.
- R3: devsel_n goes low in the clock right after a claimed address phase, and trdy_n goes low one clock later. trdy_n is only ever low while devsel_n is low.
- R4: While trdy_n is low and irdy_n is high, the phase is stretched: trdy_n stays low, ad_out holds its value, and no strobe is issued.
- R5: A write phase completes at the edge where trdy_n and irdy_n are both low. In the clock before that edge, reg_wr is high for exactly one cycle, with reg_wdata = ad_in and reg_be = ~cbe_n. A read phase gives one reg_rd cycle in the clock before trdy_n goes low, and the returned reg_rdata is then driven on ad_out with ad_oe high.
- R6: The first phase uses the I/O byte offset ad_in[2:0], or the config dword address {ad_in[7:2],00}. Each later phase of a burst adds 4 to reg_addr.
- R7: stop_n is driven low together with trdy_n on any phase whose address is the last dword of its space (I/O offset bit 2 set, or config register 63). If frame_n is still low when that phase completes, stop_n and devsel_n stay low until frame_n goes high.
- R8: After a completing phase with frame_n high, trdy_n, devsel_n and stop_n are high in the next clock.
- R9: One clock after read data is driven, par_out equals the XOR of that data and cbe_n, and par_oe is high.
- R10: The block samples par_in one clock after each write phase completes. If par_in differs from the XOR of that phase's ad_in and cbe_n, perr_n is low for exactly the following clock. Otherwise perr_n stays high.
- R11: reg_cfg is high during configuration transactions and low during I/O transactions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| ad_in | input | 32 | Address/data lines as seen by the target |
| cbe_n | input | 4 | Command (address phase) or active-low byte enables (data phase) |
| frame_n | input | 1 | Transaction framing, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| idsel | input | 1 | Configuration select |
| par_in | input | 1 | Parity supplied by the initiator |
| ad_out | output | 32 | Read data for the address/data lines |
| ad_oe | output | 1 | Enable for ad_out |
| par_out | output | 1 | Even parity for the driven read data |
| par_oe | output | 1 | Enable for par_out |
| devsel_n | output | 1 | Cycle claimed, active low |
| trdy_n | output | 1 | Target ready, active low |
| stop_n | output | 1 | Disconnect request, active low |
| perr_n | output | 1 | Data parity error, active low |
| reg_addr | output | 8 | Register-bus address |
| reg_cfg | output | 1 | Register access is to configuration space |
| reg_wdata | output | 32 | Register-bus write data |
| reg_be | output | 4 | Register-bus byte enables, active high |
| reg_wr | output | 1 | Write strobe |
| reg_rd | output | 1 | Read strobe |
| reg_rdata | input | 32 | Read data returned by the register bus |

## Verification
A wrong burst address shows up at once. On a write, the reg_addr seen with the next strobe is wrong. On a read, the data presented with trdy_n differs from the value the bench register model gives for the expected address. A phase-state error, such as a missed completion or a lost claim, shows in the handshake lines within one or two clocks. It appears as a stretched trdy_n, a missing stop_n at the window edge, devsel_n still low after the last phase, or a strobe count that does not match the phases completed. A parity error in the stored write parity surfaces two clocks after the phase, as a perr_n pulse that is missing or extra.

// File: rtl/pci_io_target.sv
module pci_io_target #(
  parameter logic [31:0] IO_BASE  = 32'h0000_0C00,
  parameter int          WIN_BITS = 3,
  parameter int          CFG_BITS = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] ad_in,
  input  logic [3:0]  cbe_n,
  input  logic        frame_n,
  input  logic        irdy_n,
  input  logic        idsel,
  input  logic        par_in,
  output logic [31:0] ad_out,
  output logic        ad_oe,
  output logic        par_out,
  output logic        par_oe,
  output logic        devsel_n,
  output logic        trdy_n,
  output logic        stop_n,
  output logic        perr_n,
  output logic [((CFG_BITS > WIN_BITS) ? CFG_BITS : WIN_BITS)-1:0] reg_addr,
  output logic        reg_cfg,
  output logic [31:0] reg_wdata,
  output logic [3:0]  reg_be,
  output logic        reg_wr,
  output logic        reg_rd,
  input  logic [31:0] reg_rdata
);
  localparam int LA_W = (CFG_BITS > WIN_BITS) ? CFG_BITS : WIN_BITS;
  localparam logic [3:0] CMD_IO_RD  = 4'b0010;
  localparam logic [3:0] CMD_IO_WR  = 4'b0011;
  localparam logic [3:0] CMD_CFG_RD = 4'b1010;
  localparam logic [3:0] CMD_CFG_WR = 4'b1011;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_XFER, S_HOLD} st_t;
  st_t st;

  logic            frame_d, irdy_d;
  logic [LA_W-1:0] addr_q;
  logic            wr_q, cfg_q;
  logic            chk_pend, chk_par;

  wire addr_phase = !frame_n && frame_d && irdy_d;
  wire io_hit  = (cbe_n == CMD_IO_RD || cbe_n == CMD_IO_WR) &&
                 (ad_in[31:WIN_BITS] == IO_BASE[31:WIN_BITS]);
  wire cfg_hit = idsel && (cbe_n == CMD_CFG_RD || cbe_n == CMD_CFG_WR) &&
                 (ad_in[1:0] == 2'b00);
  wire [LA_W-1:0] io_off  = LA_W'(ad_in[WIN_BITS-1:0]);
  wire [LA_W-1:0] cfg_off = LA_W'({ad_in[CFG_BITS-1:2], 2'b00});
  wire last_dw  = cfg_q ? (&addr_q[CFG_BITS-1:2]) : (&addr_q[WIN_BITS-1:2]);
  wire phase_ok = (st == S_XFER) && !irdy_n;

  assign reg_rd    = (st == S_FETCH) && !wr_q;
  assign reg_wr    = phase_ok && wr_q;
  assign reg_addr  = addr_q;
  assign reg_cfg   = cfg_q;
  assign reg_wdata = ad_in;
  assign reg_be    = ~cbe_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      frame_d  <= 1'b1;
      irdy_d   <= 1'b1;
      addr_q   <= '0;
      wr_q     <= 1'b0;
      cfg_q    <= 1'b0;
      devsel_n <= 1'b1;
      trdy_n   <= 1'b1;
      stop_n   <= 1'b1;
      ad_out   <= '0;
      ad_oe    <= 1'b0;
      par_out  <= 1'b0;
      par_oe   <= 1'b0;
      chk_pend <= 1'b0;
      chk_par  <= 1'b0;
      perr_n   <= 1'b1;
    end else begin
      frame_d  <= frame_n;
      irdy_d   <= irdy_n;
      par_out  <= ^{ad_out, cbe_n};
      par_oe   <= ad_oe;
      chk_pend <= reg_wr;
      if (reg_wr) chk_par <= ^{ad_in, cbe_n};
      perr_n   <= !(chk_pend && (par_in != chk_par));
      case (st)
        S_IDLE: if (addr_phase && (io_hit || cfg_hit)) begin
          st       <= S_FETCH;
          devsel_n <= 1'b0;
          wr_q     <= cbe_n[0];
          cfg_q    <= cfg_hit;
          addr_q   <= cfg_hit ? cfg_off : io_off;
        end
        S_FETCH: begin
          st     <= S_XFER;
          trdy_n <= 1'b0;
          stop_n <= !last_dw;
          if (!wr_q) begin
            ad_out <= reg_rdata;
            ad_oe  <= 1'b1;
          end
        end
        S_XFER: if (!irdy_n) begin
          trdy_n <= 1'b1;
          ad_oe  <= 1'b0;
          if (frame_n) begin
            st       <= S_IDLE;
            devsel_n <= 1'b1;
            stop_n   <= 1'b1;
          end else if (!stop_n) begin
            st <= S_HOLD;
          end else begin
            st     <= S_FETCH;
            addr_q <= addr_q + LA_W'(4);
          end
        end
        default: if (frame_n) begin
          st       <= S_IDLE;
          devsel_n <= 1'b1;
          stop_n   <= 1'b1;
        end
      endcase
    end
  end

  assert_trdy_claimed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !trdy_n |-> !devsel_n);

  assert_stop_claimed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_n |-> !devsel_n);

  assert_wait_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!trdy_n && irdy_n && !frame_n) |=> (!trdy_n && $stable(ad_out)));

  assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!trdy_n && !irdy_n && frame_n) |=> (trdy_n && devsel_n && stop_n));

  assert_perr_after_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !perr_n |-> $past(reg_wr, 2));

  assert_fetch_before_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(trdy_n) && ad_oe) |-> $past(reg_rd));
endmodule

// File: tb/pci_io_target_bench.sv
module pci_io_target_bench;
  localparam logic [31:0] BASE = 32'h0000_0C00;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ad_in = '0;
  logic [3:0]  cbe_n = 4'hF;
  logic        frame_n = 1'b1, irdy_n = 1'b1, idsel = 1'b0, par_in = 1'b0;
  logic [31:0] ad_out, reg_wdata, reg_rdata;
  logic        ad_oe, par_out, par_oe, devsel_n, trdy_n, stop_n, perr_n;
  logic [7:0]  reg_addr;
  logic        reg_cfg, reg_wr, reg_rd;
  logic [3:0]  reg_be;

  int nchk = 0, nfail = 0, nwr = 0, nrd = 0, nperr = 0;
  logic ended = 1'b0;

  always #2 clk = ~clk;

  function automatic logic [31:0] rdfn(input logic [7:0] a, input logic c);
    return {a, ~a, a ^ 8'h5A, 7'h0, c} ^ 32'h1357_9BDF;
  endfunction

  function automatic logic exp_claim(input logic [3:0] cmd, input logic [31:0] a, input logic s);
    return ((cmd == 4'b0010 || cmd == 4'b0011) && a[31:3] == BASE[31:3]) ||
           (s && (cmd == 4'b1010 || cmd == 4'b1011) && a[1:0] == 2'b00);
  endfunction

  assign reg_rdata = rdfn(reg_addr, reg_cfg);

  pci_io_target #(.IO_BASE(BASE)) u_pci_io_target (
    .clk(clk), .rst_n(rst_n), .ad_in(ad_in), .cbe_n(cbe_n), .frame_n(frame_n),
    .irdy_n(irdy_n), .idsel(idsel), .par_in(par_in), .ad_out(ad_out), .ad_oe(ad_oe),
    .par_out(par_out), .par_oe(par_oe), .devsel_n(devsel_n), .trdy_n(trdy_n),
    .stop_n(stop_n), .perr_n(perr_n), .reg_addr(reg_addr), .reg_cfg(reg_cfg),
    .reg_wdata(reg_wdata), .reg_be(reg_be), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_rdata(reg_rdata));

  always @(posedge clk) begin
    if (reg_wr) nwr++;
    if (reg_rd) nrd++;
    if (rst_n && !perr_n) nperr++;
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic txn(input logic [3:0] cmd, input logic [31:0] adr, input logic sel,
                     input int len, input int wmax, input logic bad);
    logic claim, wr, cfg, fin, stp;
    logic [7:0] a0, ea;
    logic [31:0] wd, pdat;
    logic [3:0] be, pbe;
    int allowed, nexp, k, wcnt, wr0, rd0, pe0;
    cfg = (cmd[3:1] == 3'b101);
    wr = cmd[0];
    claim = exp_claim(cmd, adr, sel);
    a0 = cfg ? {adr[7:2], 2'b00} : {5'd0, adr[2:0]};
    allowed = cfg ? (64 - int'(adr[7:2])) : (adr[2] ? 1 : 2);
    nexp = (len < allowed) ? len : allowed;
    wr0 = nwr; rd0 = nrd; pe0 = nperr;
    @(negedge clk);
    frame_n = 1'b0; ad_in = adr; cbe_n = cmd; idsel = sel; irdy_n = 1'b1;
    @(negedge clk);
    idsel = 1'b0;
    if (!claim) begin
      ad_in = $urandom; cbe_n = 4'($urandom); irdy_n = 1'b0; frame_n = 1'b1;
      for (int i = 0; i < 4; i++) begin
        #1;
        chk(devsel_n && trdy_n && !reg_wr && !reg_rd, "R2 unclaimed cycle stays quiet",
            {29'd0, devsel_n, trdy_n, reg_wr}, 32'h6);
        @(negedge clk);
      end
      irdy_n = 1'b1;
      chk(nwr == wr0 && nrd == rd0, "R2 no strobes on ignored cycle", 32'(nwr - wr0 + nrd - rd0), 0);
      return;
    end
    #1;
    chk(!devsel_n && trdy_n, "R3 claim timing", {30'd0, devsel_n, trdy_n}, 32'h1);
    wd = $urandom; be = 4'($urandom);
    ad_in = wr ? wd : 32'h0; cbe_n = be; frame_n = (len == 1);
    wcnt = (len > 1) ? $urandom_range(wmax, 0) : 0;
    k = 0; fin = 1'b0;
    for (int c = 0; c < 80 && !fin; c++) begin
      irdy_n = (wcnt > 0);
      if (wcnt > 0) wcnt--;
      #1;
      ea = a0 + 8'(4 * k);
      if (!trdy_n && irdy_n && !wr)
        chk(ad_out == rdfn(ea, cfg) && !reg_rd, "R4 data held in wait state", ad_out, rdfn(ea, cfg));
      if (!trdy_n && !irdy_n) begin
        stp = !stop_n;
        chk(stp == (k == allowed - 1), "R7 disconnect at window end", 32'(stp), 32'(k == allowed - 1));
        chk(reg_addr == ea, "R6 burst address", 32'(reg_addr), 32'(ea));
        chk(reg_cfg == cfg, "R11 space flag", 32'(reg_cfg), 32'(cfg));
        if (wr)
          chk(reg_wr && reg_wdata == wd && reg_be == ~be, "R5 write strobe", reg_wdata, wd);
        else
          chk(ad_oe && ad_out == rdfn(ea, cfg), "R5 read data", ad_out, rdfn(ea, cfg));
        pdat = wr ? wd : rdfn(ea, cfg);
        pbe = be;
        k++;
        @(negedge clk);
        if (wr) par_in = (^{pdat, pbe}) ^ (bad && k == 1);
        else chk(par_oe && par_out == ^{pdat, pbe}, "R9 read parity", 32'(par_out), 32'(^{pdat, pbe}));
        if (k == len || stp) begin
          frame_n = 1'b1; irdy_n = 1'b1; fin = 1'b1;
        end else begin
          wd = $urandom; be = 4'($urandom);
          ad_in = wr ? wd : 32'h0; cbe_n = be; frame_n = (k == len - 1);
          wcnt = (k < len - 1) ? $urandom_range(wmax, 0) : 0;
        end
      end else begin
        @(negedge clk);
      end
    end
    repeat (3) @(negedge clk);
    #1;
    chk(devsel_n && trdy_n && stop_n, "R8 release after last phase",
        {29'd0, devsel_n, trdy_n, stop_n}, 32'h7);
    chk(k == nexp, "R7 phases before disconnect", 32'(k), 32'(nexp));
    chk(nwr - wr0 == (wr ? nexp : 0) && nrd - rd0 == (wr ? 0 : nexp), "R5 one strobe per phase",
        32'(nwr - wr0 + nrd - rd0), 32'(nexp));
    chk(nperr - pe0 == ((bad && wr) ? 1 : 0), "R10 parity error pulse",
        32'(nperr - pe0), 32'((bad && wr) ? 1 : 0));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      nfail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    #1;
    chk(devsel_n && trdy_n && stop_n && perr_n && !ad_oe && !par_oe && !reg_wr && !reg_rd,
        "R1 reset state", {26'd0, devsel_n, trdy_n, stop_n, perr_n, ad_oe, par_oe}, 32'h3C);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    txn(4'b0011, BASE | 32'h0, 1'b0, 3, 2, 1'b0);
    txn(4'b0010, BASE | 32'h1, 1'b0, 2, 2, 1'b0);
    txn(4'b0010, BASE | 32'h4, 1'b0, 2, 0, 1'b0);
    txn(4'b0011, BASE | 32'h6, 1'b0, 1, 0, 1'b1);
    txn(4'b1010, 32'h0000_00F8, 1'b1, 3, 1, 1'b0);
    txn(4'b1011, 32'h0000_0010, 1'b1, 2, 1, 1'b1);
    txn(4'b1010, 32'h0000_0011, 1'b1, 1, 0, 1'b0);
    txn(4'b1010, 32'h0000_0010, 1'b0, 1, 0, 1'b0);
    txn(4'b0110, BASE, 1'b0, 1, 0, 1'b0);
    txn(4'b0010, BASE | 32'h8, 1'b0, 1, 0, 1'b0);
    for (int n = 0; n < 300; n++) begin
      int r;
      logic [3:0] cmd;
      logic [31:0] a;
      logic s;
      r = $urandom_range(9, 0);
      s = 1'b0;
      case (r)
        0, 1, 2: cmd = 4'b0010;
        3, 4, 5: cmd = 4'b0011;
        6:       cmd = 4'b1010;
        7:       cmd = 4'b1011;
        8:       cmd = 4'b0110;
        default: cmd = 4'b0111;
      endcase
      if (cmd[3]) begin
        a = {$urandom_range(255, 0) == 0 ? 24'h1 : 24'h0, 6'($urandom), ($urandom_range(9, 0) == 0) ? 2'b01 : 2'b00};
        s = ($urandom_range(4, 0) != 0);
      end else if ($urandom_range(4, 0) != 0) begin
        a = BASE | 32'($urandom_range(7, 0));
      end else begin
        a = $urandom;
      end
      txn(cmd, a, s, $urandom_range(4, 1), 2, ($urandom_range(4, 0) == 0));
    end
    if (!ended) begin
      ended = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule